// File: doc/BRIEF.md
# Zero-Latency CPU Memory Port to Wishbone Master Bridge

This block connects a processor's simple memory port (valid/ready handshake with address, write data, byte strobes and read data) to a classic Wishbone master port. Request and acknowledge pass through combinational paths, with no register stage in between. The bus strobe rises in the same cycle the processor raises valid. The processor sees ready in the same cycle the slave raises ACK. Both sides are assumed to drive registered outputs, so these paths add only a little logic depth and no cycles.

A two-state controller sits beside the combinational paths. After an acknowledge it keeps the strobe low until the processor has dropped valid for at least one cycle. A request that is still held after completion therefore never starts a second bus cycle. Writes are marked by a nonzero strobe field. Reads use all byte lanes. The bus-side address, data and lane-select outputs are zero whenever no cycle is in progress.

Top module: `cpu_wb_bridge`

## Requirements
- R1: While rst_n is low, wb_cyc, wb_stb and cpu_ready are 0, whatever cpu_valid and wb_ack are. The controller leaves reset ready to accept a request.
- R2: In the ready-to-accept state, wb_cyc and wb_stb equal cpu_valid in the same cycle.
- R3: While wb_stb is 1, cpu_ready equals wb_ack in the same cycle.
- R4: During a bus cycle, wb_we is 1 exactly when cpu_wstrb is nonzero. wb_sel equals cpu_wstrb on a write and is all ones on a read.
- R5: During a bus cycle, wb_adr equals cpu_addr and wb_dat_w equals cpu_wdata. With no bus cycle, wb_adr, wb_dat_w, wb_sel and wb_we are all 0.
- R6: cpu_rdata equals wb_dat_r while cpu_ready is 1 and is 0 otherwise.
- R7: After an acknowledged cycle, wb_stb stays 0 for as long as cpu_valid stays 1. A new cycle can start only after a cycle in which cpu_valid was 0.
- R8: A wb_ack that arrives while wb_stb is 0 leaves cpu_ready at 0.
- R9: A bus cycle keeps wb_stb at 1 through every wait cycle without ACK, for as long as cpu_valid is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by processor and bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Request complete, same cycle as ACK |
| cpu_addr | input | AW | Request byte address |
| cpu_wdata | input | DW | Write data |
| cpu_wstrb | input | DW/8 | Byte strobes, zero for a read |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| wb_cyc | output | 1 | Bus cycle in progress |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | AW | Bus address |
| wb_dat_w | output | DW | Bus write data |
| wb_sel | output | DW/8 | Byte lane select |
| wb_ack | input | 1 | Slave acknowledge |
| wb_dat_r | input | DW | Slave read data |

## Verification
If the controller wrongly stays in its post-acknowledge state, the next request's strobe is missing in the very cycle valid rises, so a stalled processor shows up at once. If it wrongly stays in its accepting state, a second strobe appears in the cycle right after ACK while valid is still held, and that duplicated bus cycle shows at the ports one cycle after completion. The stimulus holds valid for several cycles after completion and drives stray acknowledges in those cycles, so both faults are exposed within one or two cycles.

// File: rtl/cpu_wb_bridge_pkg.sv
// Package: shared types for the processor-to-Wishbone bridge.
// Assumes nothing beyond a single clock domain.
package cpu_wb_bridge_pkg;

    // Controller states: accepting a request, or waiting for valid to drop
    typedef enum logic [0:0] {
        BR_ACCEPT = 1'b0,
        BR_DRAIN  = 1'b1
    } br_state_e;

endpackage

// File: rtl/cpu_wb_bridge_ctrl.sv
// Module: cpu_wb_bridge_ctrl
// Decides when a bus cycle is active. The strobe comes combinationally from
// valid in the accepting state. After an acknowledge, the controller waits
// until valid drops, so a held request is never issued twice.
// Assumes the processor drops valid for at least one cycle between requests.
module cpu_wb_bridge_ctrl
    import cpu_wb_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic bus_ack,
    output logic cycle_active
);

    br_state_e state_q, state_d;

    // Active bus cycle: accepting state, out of reset, request present
    always_comb begin
        cycle_active = rst_n && (state_q == BR_ACCEPT) && req_valid;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BR_ACCEPT: if (cycle_active && bus_ack) state_d = BR_DRAIN;
            BR_DRAIN:  if (!req_valid)              state_d = BR_ACCEPT;
            default:                                state_d = BR_ACCEPT;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BR_ACCEPT;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/cpu_wb_bridge_req.sv
// Module: cpu_wb_bridge_req
// Request path: gates address, write data, lane selects and write enable
// onto the bus while a cycle is active, and drives them to zero otherwise.
// Purely combinational; assumes the request fields are registered upstream.
module cpu_wb_bridge_req #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            cycle_active,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_wstrb,
    output logic            bus_we,
    output logic [AW-1:0]   bus_adr,
    output logic [DW-1:0]   bus_dat_w,
    output logic [DW/8-1:0] bus_sel
);

    localparam int LANES = DW / 8;

    logic is_write;

    // Write detection from nonzero strobes, gated by the active cycle
    always_comb begin
        is_write = |req_wstrb;
        bus_we   = cycle_active && is_write;
        bus_adr  = cycle_active ? req_addr : '0;
    end

    // Per byte lane: select and write data
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            bus_sel[g]             = cycle_active && (is_write ? req_wstrb[g] : 1'b1);
            bus_dat_w[8*g +: 8]    = cycle_active ? req_wdata[8*g +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/cpu_wb_bridge_rsp.sv
// Module: cpu_wb_bridge_rsp
// Response path: turns a slave acknowledge into processor ready in the same
// cycle, and passes read data only while ready is high.
// Combinational; assumes the slave's ACK and data are registered.
module cpu_wb_bridge_rsp #(
    parameter int DW = 32
) (
    input  logic          cycle_active,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_dat_r,
    output logic          rsp_ready,
    output logic [DW-1:0] rsp_rdata
);

    // Ready only for an acknowledge of the active cycle; data masked otherwise
    always_comb begin
        rsp_ready = cycle_active && bus_ack;
        rsp_rdata = rsp_ready ? bus_dat_r : '0;
    end

endmodule

// File: rtl/cpu_wb_bridge.sv
// Module: cpu_wb_bridge (top)
// Zero-latency bridge from a processor valid/ready memory port to a classic
// Wishbone master. It adds no register stage in either direction. CYC and
// STB are the same signal, since one request maps to one single-beat cycle.
// Assumes one clock for both sides and registered outputs on both sides.
module cpu_wb_bridge #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_valid,
    output logic            cpu_ready,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    input  logic [DW/8-1:0] cpu_wstrb,
    output logic [DW-1:0]   cpu_rdata,
    output logic            wb_cyc,
    output logic            wb_stb,
    output logic            wb_we,
    output logic [AW-1:0]   wb_adr,
    output logic [DW-1:0]   wb_dat_w,
    output logic [DW/8-1:0] wb_sel,
    input  logic            wb_ack,
    input  logic [DW-1:0]   wb_dat_r
);

    logic active;

    cpu_wb_bridge_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (cpu_valid),
        .bus_ack      (wb_ack),
        .cycle_active (active)
    );

    cpu_wb_bridge_req #(.AW(AW), .DW(DW)) u_req (
        .cycle_active (active),
        .req_addr     (cpu_addr),
        .req_wdata    (cpu_wdata),
        .req_wstrb    (cpu_wstrb),
        .bus_we       (wb_we),
        .bus_adr      (wb_adr),
        .bus_dat_w    (wb_dat_w),
        .bus_sel      (wb_sel)
    );

    cpu_wb_bridge_rsp #(.DW(DW)) u_rsp (
        .cycle_active (active),
        .bus_ack      (wb_ack),
        .bus_dat_r    (wb_dat_r),
        .rsp_ready    (cpu_ready),
        .rsp_rdata    (cpu_rdata)
    );

    // Cycle and strobe driven together
    always_comb begin
        wb_cyc = active;
        wb_stb = active;
    end

endmodule

// File: rtl/cpu_wb_bridge_checker.sv
// Module: cpu_wb_bridge_checker
// Port-level properties of the bridge, attached to the top by bind.
module cpu_wb_bridge_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_valid,
    input logic            cpu_ready,
    input logic [DW/8-1:0] cpu_wstrb,
    input logic [DW-1:0]   cpu_rdata,
    input logic            wb_cyc,
    input logic            wb_stb,
    input logic            wb_we,
    input logic [AW-1:0]   wb_adr,
    input logic [DW/8-1:0] wb_sel,
    input logic            wb_ack
);

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!wb_cyc && !wb_stb && !cpu_ready));

    a_r2_stb_on_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_valid) |-> (wb_stb && wb_cyc));

    a_r3_ready_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && wb_ack) |-> cpu_ready);

    a_r4_read_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && cpu_wstrb == '0) |-> (!wb_we && wb_sel == '1));

    a_r5_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_stb |-> (wb_adr == '0 && wb_sel == '0 && !wb_we));

    a_r6_rdata_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> (cpu_rdata == '0));

    a_r7_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && wb_ack) |=> !wb_stb);

    a_r8_stray_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_stb |-> !cpu_ready);

    a_r9_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && !wb_ack) |=> (!cpu_valid || wb_stb));

endmodule

bind cpu_wb_bridge cpu_wb_bridge_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_ready (cpu_ready),
    .cpu_wstrb (cpu_wstrb),
    .cpu_rdata (cpu_rdata),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_we     (wb_we),
    .wb_adr    (wb_adr),
    .wb_sel    (wb_sel),
    .wb_ack    (wb_ack)
);

// File: tb/cpu_wb_bridge_bench.sv
// Bench: random and directed requests against a slave model with variable
// acknowledge latency. Expected outputs are computed from the requirements.
module cpu_wb_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_valid;
    logic          cpu_ready;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic [SW-1:0] cpu_wstrb;
    logic [DW-1:0] cpu_rdata;
    logic          wb_cyc, wb_stb, wb_we, wb_ack;
    logic [AW-1:0] wb_adr;
    logic [DW-1:0] wb_dat_w, wb_dat_r;
    logic [SW-1:0] wb_sel;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  blocked  = 1'b0;   // model: acknowledged and valid still held

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_wb_bridge #(.AW(AW), .DW(DW)) u_cpu_wb_bridge (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_wstrb(cpu_wstrb), .cpu_rdata(cpu_rdata),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_ack(wb_ack), .wb_dat_r(wb_dat_r)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [SW-1:0] exp_sel(input logic act, input logic [SW-1:0] s);
        if (!act) return '0;
        return (s != '0) ? s : {SW{1'b1}};
    endfunction

    // Check every output at the falling edge, then advance the model one edge
    task automatic step();
        logic e_stb, e_rdy;
        string ts, tr;
        @(negedge clk);
        e_stb = rst_n && cpu_valid && !blocked;
        e_rdy = e_stb && wb_ack;
        ts = !rst_n ? "R1" : (blocked ? "R7" : ((e_stb && !wb_ack) ? "R9" : "R2"));
        tr = !rst_n ? "R1" : (e_stb ? "R3" : "R8");
        chk(ts, {63'd0, wb_stb}, {63'd0, e_stb});
        chk(ts, {63'd0, wb_cyc}, {63'd0, e_stb});
        chk(tr, {63'd0, cpu_ready}, {63'd0, e_rdy});
        chk("R4", {63'd0, wb_we}, {63'd0, e_stb && (cpu_wstrb != '0)});
        chk("R4", {60'd0, wb_sel}, {60'd0, exp_sel(e_stb, cpu_wstrb)});
        chk("R5", {32'd0, wb_adr}, {32'd0, e_stb ? cpu_addr : 32'd0});
        chk("R5", {32'd0, wb_dat_w}, {32'd0, e_stb ? cpu_wdata : 32'd0});
        chk("R6", {32'd0, cpu_rdata}, {32'd0, e_rdy ? wb_dat_r : 32'd0});
        if (!rst_n)             blocked = 1'b0;
        else if (e_stb && wb_ack) blocked = 1'b1;
        else if (!cpu_valid)    blocked = 1'b0;
        @(posedge clk);
        #1;
    endtask

    // One request: wait cycles, ACK, held-valid cycles with optional stray ACK, drop
    task automatic txn(input bit wr, input int lat, input int hold, input bit stray);
        cpu_valid = 1'b1;
        cpu_addr  = $urandom;
        cpu_wdata = $urandom;
        cpu_wstrb = wr ? SW'($urandom_range(1, (1 << SW) - 1)) : '0;
        wb_ack    = 1'b0;
        for (int i = 0; i < lat; i++) begin
            wb_dat_r = $urandom;
            step();
        end
        wb_ack   = 1'b1;
        wb_dat_r = $urandom;
        step();
        wb_ack = stray;
        for (int i = 0; i < hold; i++) begin
            wb_dat_r = $urandom;
            step();
        end
        cpu_valid = 1'b0;
        wb_ack    = stray;
        step();
        wb_ack = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rst_n     = 1'b0;
        cpu_valid = 1'b1;     // R1: request and ACK present during reset
        cpu_addr  = 32'h1234_5678;
        cpu_wdata = 32'hdead_beef;
        cpu_wstrb = 4'hf;
        wb_ack    = 1'b1;
        wb_dat_r  = 32'h0bad_f00d;
        step();
        step();
        cpu_valid = 1'b0;
        wb_ack    = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        // Directed corner cases
        txn(1'b1, 0, 0, 1'b0);   // R2 R3: immediate ACK
        txn(1'b0, 0, 3, 1'b1);   // R7 R8: held valid with stray ACKs
        txn(1'b0, 3, 0, 1'b0);   // R9 R4: read with long wait
        txn(1'b1, 2, 2, 1'b1);   // R6 R5: write, wait, hold
        // Random traffic
        for (int n = 0; n < 400; n++) begin
            txn(1'($urandom_range(0, 1)), $urandom_range(0, 3),
                $urandom_range(0, 2), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) step();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule